// File: doc/BRIEF.md
# Quad-Word Write-Merging Buffer

This block sits between a bus slave and a memory command engine. It gathers byte, halfword and word writes into 16-byte quad-word bursts, so that memory sees one burst in place of many narrow writes. It holds two quad-word slots. At any time at most one slot is merging. The other slot is either empty or waiting for the memory engine to accept its contents. Each slot keeps a valid bit for every byte. On write-back, the inverse of that mask goes out as per-byte ignore lines, so bytes that were never written leave memory untouched.

A merging slot is written back on any of four events: a write to a different quad word (the slots swap roles), a read to an address the buffer holds (the read waits until the write-back is accepted), expiry of a retriggerable inactivity timer, or clearing of the enable input. Reads that miss the buffer pass straight through in the same cycle. Memory read data and memory timing are not part of this block. Other memory masters reach memory through their own paths and never touch this buffer.

Top module: `merge_wbuf`

## Requirements
- R1: Writes to the quad word held by the merging slot are merged into it in any order and with any lane pattern. The word within the quad word is `busAddr[1:0]`. Strobe bit i selects byte i of the word, which is byte 4*w+i of the quad word. A later write to a byte replaces the earlier value. No write-back starts while merging continues.
- R2: A write to a different quad word, made while a slot is merging and the other slot is empty, is accepted in the same cycle. From the next cycle the old slot is offered to memory, while the new data merges in the other slot.
- R3: If one slot is waiting for memory and the other is merging, a write to a third quad word is held off with `busReady` low. It is accepted in the cycle after the waiting slot is taken by memory.
- R4: A read whose quad address matches an occupied slot is held off with `busReady` low, and the matching merging slot is flushed. `rdPass` goes high only after memory has accepted that write-back.
- R5: A read that matches no occupied slot raises `busReady` and `rdPass` in the same cycle, with `rdQa` equal to the read's quad address.
- R6: With a timeout value T > 0 loaded, `memValid` rises exactly T cycles after the clock edge that accepted the last write into the merging slot. Every accepted write into that slot restarts the count.
- R7: A timeout value of 0 means the merging slot is never flushed by the timer.
- R8: Clearing `enable` flushes the merging slot, and `memValid` is high from the next cycle. A write accepted while `enable` is low is offered to memory on its own from the next cycle.
- R9: `memByteOff[b]` is 1 exactly for the bytes of the offered quad word that were never written. Byte b of the burst is `memData[8*b+7:8*b]`.
- R10: While `memValid` is high and `memReady` is low, `memAddr`, `memData` and `memByteOff` stay unchanged. When both slots wait, the older one is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Buffer enable; low forces write-back |
| timeout | input | TMO_W | Inactivity count in cycles; 0 turns the timer off |
| busValid | input | 1 | Bus request present |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | ADDR_W | Word address |
| busWData | input | DATA_W | Write data, lane aligned |
| busStrb | input | DATA_W/8 | Byte lane strobes |
| busReady | output | 1 | Request taken this cycle |
| rdPass | output | 1 | Read forwarded to memory this cycle |
| rdQa | output | ADDR_W-2 | Quad address of the forwarded read |
| memValid | output | 1 | Quad-word write-back offered |
| memReady | input | 1 | Memory engine takes the write-back |
| memAddr | output | ADDR_W-2 | Quad address of the write-back |
| memData | output | 4*DATA_W | Quad-word data |
| memByteOff | output | DATA_W/2 | 1 = memory must ignore this byte |

## Verification
The bench builds the block with its defaults: a 16-bit word address, 32-bit words and an 8-bit timeout. The timeout is driven at run time, with values 0 and 6. The small timeout lets the bench count the exact expiry cycle and show a mid-count restart within a few dozen cycles. A zero timeout keeps a slot merging long enough to test the read-hit and disable paths. Because the bench controls `memReady`, it can hold one slot in the waiting state and so reach the two-slot stall and the stability of the offered burst.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_MERGE = 2'd1,
    SL_FLUSH = 2'd2
  } slotSt_t;

  typedef struct packed {
    logic wrEn;     // store lanes into a slot
    logic wrSel;    // which slot
    logic wrFresh;  // slot starts a new quad word: clear its mask
    logic outSel;   // slot presented to memory
  } dpStrobe_t;
endpackage

// File: rtl/mwb_dpath.sv
module mwb_dpath
  import mwb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int QW_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     stb,
  input  logic [ADDR_W-$clog2(QW_WORDS)-1:0] wrQa,
  input  logic [$clog2(QW_WORDS)-1:0]   wrWord,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W/8-1:0]           wrStrb,
  output logic [1:0][ADDR_W-$clog2(QW_WORDS)-1:0] slotQa,
  output logic [ADDR_W-$clog2(QW_WORDS)-1:0] memAddr,
  output logic [QW_WORDS*DATA_W-1:0]    memData,
  output logic [QW_WORDS*DATA_W/8-1:0]  memByteOff
);
  localparam int BYTES  = DATA_W / 8;
  localparam int QBYTES = BYTES * QW_WORDS;
  localparam int WSEL_W = $clog2(QW_WORDS);
  localparam int QA_W   = ADDR_W - WSEL_W;

  logic [1:0][QBYTES-1:0][7:0] slotDat;
  logic [1:0][QBYTES-1:0]      slotMsk;
  logic [1:0][QA_W-1:0]        slotAdr;
  logic [QBYTES-1:0]           laneHit;
  logic [QBYTES-1:0][7:0]      laneByte;

  always_comb begin
    for (int b = 0; b < QBYTES; b++) begin
      laneHit[b]  = (WSEL_W'(b / BYTES) == wrWord) && wrStrb[b % BYTES];
      laneByte[b] = wrData[8*(b % BYTES) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotDat <= '0;
      slotMsk <= '0;
      slotAdr <= '0;
    end else if (stb.wrEn) begin
      slotAdr[stb.wrSel] <= wrQa;
      for (int b = 0; b < QBYTES; b++) begin
        if (laneHit[b]) begin
          slotDat[stb.wrSel][b] <= laneByte[b];
          slotMsk[stb.wrSel][b] <= 1'b1;
        end else if (stb.wrFresh) begin
          slotMsk[stb.wrSel][b] <= 1'b0;
        end
      end
    end
  end

  assign slotQa     = slotAdr;
  assign memAddr    = slotAdr[stb.outSel];
  assign memData    = slotDat[stb.outSel];
  assign memByteOff = ~slotMsk[stb.outSel];
endmodule

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
#(
  parameter int QA_W  = 14,
  parameter int TMO_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [TMO_W-1:0]      timeout,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [QA_W-1:0]       busQa,
  input  logic [1:0][QA_W-1:0]  slotQa,
  input  logic                  memReady,
  output logic                  busReady,
  output logic                  rdPass,
  output logic                  memValid,
  output dpStrobe_t             stb
);
  slotSt_t          slotSt [2];
  logic             curSel;
  logic [TMO_W-1:0] tmrCnt;

  logic othSel, curMerge, curHit, isWr, isRd;
  logic [1:0] rdHit;
  logic wrCur, wrOth, wrGo, tmrExpire, flushCur, memDone, outSel;

  always_comb begin
    othSel   = ~curSel;
    isWr     = busValid && busWrite;
    isRd     = busValid && !busWrite;
    curMerge = (slotSt[curSel] == SL_MERGE);
    curHit   = curMerge && enable && (slotQa[curSel] == busQa);
    for (int s = 0; s < 2; s++)
      rdHit[s] = (slotSt[s] != SL_EMPTY) && (slotQa[s] == busQa);
    wrCur    = curHit || (slotSt[curSel] == SL_EMPTY);
    wrOth    = !wrCur && (slotSt[othSel] == SL_EMPTY);
    wrGo     = isWr && (wrCur || wrOth);
    busReady = busWrite ? (wrCur || wrOth) : (rdHit == 2'b00);
    rdPass   = isRd && (rdHit == 2'b00);
    memValid = (slotSt[0] == SL_FLUSH) || (slotSt[1] == SL_FLUSH);
    outSel   = (slotSt[othSel] == SL_FLUSH) ? othSel : curSel;
    memDone  = memValid && memReady;
    tmrExpire = curMerge && (tmrCnt == TMO_W'(1)) && !(wrGo && wrCur);
    flushCur = curMerge && (!enable || tmrExpire ||
                            (isRd && rdHit[curSel]) || (wrGo && wrOth));
    stb.wrEn    = wrGo;
    stb.wrSel   = wrCur ? curSel : othSel;
    stb.wrFresh = !curHit;
    stb.outSel  = outSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotSt[0] <= SL_EMPTY;
      slotSt[1] <= SL_EMPTY;
      curSel    <= 1'b0;
      tmrCnt    <= '0;
    end else begin
      if (memDone)
        slotSt[outSel] <= SL_EMPTY;
      if (flushCur)
        slotSt[curSel] <= SL_FLUSH;
      if (wrGo)
        slotSt[stb.wrSel] <= enable ? SL_MERGE : SL_FLUSH;
      if (wrGo && wrOth)
        curSel <= othSel;

      if (wrGo && enable)
        tmrCnt <= timeout;
      else if (!curMerge || flushCur)
        tmrCnt <= '0;
      else if (tmrCnt != '0)
        tmrCnt <= tmrCnt - 1'b1;
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import mwb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int QW_WORDS = 4,
  parameter int TMO_W    = 8,
  localparam int QA_W    = ADDR_W - $clog2(QW_WORDS),
  localparam int QBYTES  = QW_WORDS * DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [TMO_W-1:0]       timeout,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWData,
  input  logic [DATA_W/8-1:0]    busStrb,
  output logic                   busReady,
  output logic                   rdPass,
  output logic [QA_W-1:0]        rdQa,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [QA_W-1:0]        memAddr,
  output logic [QW_WORDS*DATA_W-1:0] memData,
  output logic [QBYTES-1:0]      memByteOff
);
  localparam int WSEL_W = $clog2(QW_WORDS);

  dpStrobe_t            stb;
  logic [1:0][QA_W-1:0] slotQa;
  logic [QA_W-1:0]      busQa;

  assign busQa = busAddr[ADDR_W-1:WSEL_W];
  assign rdQa  = busQa;

  mwb_ctrl #(.QA_W(QA_W), .TMO_W(TMO_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .timeout(timeout),
    .busValid(busValid), .busWrite(busWrite), .busQa(busQa),
    .slotQa(slotQa), .memReady(memReady), .busReady(busReady),
    .rdPass(rdPass), .memValid(memValid), .stb(stb)
  );

  mwb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QW_WORDS(QW_WORDS)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrQa(busQa),
    .wrWord(busAddr[WSEL_W-1:0]), .wrData(busWData), .wrStrb(busStrb),
    .slotQa(slotQa), .memAddr(memAddr), .memData(memData),
    .memByteOff(memByteOff)
  );
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int QA_W   = 14,
  parameter int QBITS  = 128,
  parameter int QBYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              busValid,
  input logic              busWrite,
  input logic              busReady,
  input logic              rdPass,
  input logic [QA_W-1:0]   rdQa,
  input logic              memValid,
  input logic              memReady,
  input logic [QA_W-1:0]   memAddr,
  input logic [QBITS-1:0]  memData,
  input logic [QBYTES-1:0] memByteOff
);
  // R3: a write is only refused while some slot waits for memory
  p_stall_only_flushing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !busReady) |-> memValid);

  // R4: a read never passes while its own quad word is still on offer
  p_read_after_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdPass |-> !(memValid && memAddr == rdQa));

  // R5: pass only for an accepted read request
  p_read_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdPass |-> (busValid && !busWrite && busReady));

  // R8: a write taken while disabled is offered next cycle
  p_disabled_write_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busReady && !enable) |=> memValid);

  // R9: an offered burst always carries at least one written byte
  p_mask_some_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memByteOff != {QBYTES{1'b1}}));

  // R10: the offer holds still until taken
  p_hold_payload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) &&
                                 $stable(memData) && $stable(memByteOff)));
endmodule

bind merge_wbuf mwb_checker #(.QA_W(QA_W), .QBITS(QW_WORDS*DATA_W), .QBYTES(QBYTES)) i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .busValid(busValid),
  .busWrite(busWrite), .busReady(busReady), .rdPass(rdPass), .rdQa(rdQa),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
  .memData(memData), .memByteOff(memByteOff)
);

// File: tb/test_merge_wbuf.sv
module test_merge_wbuf;
  localparam logic [13:0] QA_A = 14'h0010, QA_B = 14'h0020,
                          QA_C = 14'h0030, QA_D = 14'h0044;

  logic         clk = 1'b0, rstN = 1'b0, enable = 1'b1;
  logic [7:0]   timeout = 8'd0;
  logic         busValid = 1'b0, busWrite = 1'b0;
  logic [15:0]  busAddr = '0;
  logic [31:0]  busWData = '0;
  logic [3:0]   busStrb = '0;
  logic         busReady, rdPass, memValid;
  logic         memReady = 1'b0;
  logic [13:0]  rdQa, memAddr;
  logic [127:0] memData;
  logic [15:0]  memByteOff;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  merge_wbuf i_merge_wbuf (
    .clk(clk), .rstN(rstN), .enable(enable), .timeout(timeout),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busStrb(busStrb), .busReady(busReady),
    .rdPass(rdPass), .rdQa(rdQa), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .memByteOff(memByteOff)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] keepBytes(input logic [127:0] d, input logic [15:0] off);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = off[b] ? 8'h00 : d[8*b +: 8];
    return r;
  endfunction

  task automatic doWrite(input logic [13:0] qa, input logic [1:0] w,
                         input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = {qa, w}; busWData = d; busStrb = s;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic tReset;
    check(memValid == 1'b0, "R10", "memValid after reset", 128'(memValid), 128'd0);
    check(rdPass == 1'b0, "R5", "rdPass idle after reset", 128'(rdPass), 128'd0);
  endtask

  task automatic tMergeSwap;
    logic [127:0] expD;
    logic [15:0]  expOff;
    timeout = 8'd0; memReady = 1'b0;
    doWrite(QA_A, 2'd0, 32'h000000AA, 4'b0001);
    doWrite(QA_A, 2'd2, 32'hBBCC0000, 4'b1100);
    doWrite(QA_A, 2'd3, 32'h11223344, 4'b1111);
    doWrite(QA_A, 2'd0, 32'h00000055, 4'b0001);
    @(negedge clk);
    check(memValid == 1'b0, "R1", "no write-back while merging", 128'(memValid), 128'd0);
    doWrite(QA_B, 2'd1, 32'h0000EE00, 4'b0010);
    @(negedge clk);
    expD = '0; expD[7:0] = 8'h55; expD[87:80] = 8'hCC; expD[95:88] = 8'hBB;
    expD[127:96] = 32'h11223344;
    expOff = 16'h03FE;
    check(memValid == 1'b1, "R2", "old slot offered after swap", 128'(memValid), 128'd1);
    check(memAddr == QA_A, "R2", "offered address", 128'(memAddr), 128'(QA_A));
    check(memByteOff == expOff, "R9", "byte ignore lines", 128'(memByteOff), 128'(expOff));
    check(keepBytes(memData, expOff) == expD, "R1", "merged bytes",
          keepBytes(memData, expOff), expD);
    repeat (3) @(negedge clk);
    check(memValid && memAddr == QA_A && memByteOff == expOff, "R10",
          "offer held while not ready", 128'(memAddr), 128'(QA_A));
  endtask

  task automatic tStall;
    bit stalledOk = 1'b1;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = {QA_C, 2'd0};
    busWData = 32'hC0C0C0C0; busStrb = 4'b1111;
    #1;
    if (busReady) stalledOk = 1'b0;
    repeat (2) begin @(negedge clk); #1; if (busReady) stalledOk = 1'b0; end
    check(stalledOk, "R3", "third address held off", 128'(busReady), 128'd0);
    memReady = 1'b1;
    @(negedge clk); #1;
    check(busReady == 1'b1, "R3", "accepted after slot freed", 128'(busReady), 128'd1);
    @(posedge clk); #1;
    busValid = 1'b0;
    @(negedge clk);
    check(memValid && memAddr == QA_B, "R2", "second slot offered on swap",
          128'(memAddr), 128'(QA_B));
    check(memByteOff == 16'hFFDF, "R9", "single byte burst mask",
          128'(memByteOff), 128'hFFDF);
    @(negedge clk);
  endtask

  task automatic tReadHit;
    bit sawFlush = 1'b0, passed = 1'b0;
    memReady = 1'b1;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = {QA_C, 2'd1};
    #1;
    check(busReady == 1'b0, "R4", "read to buffered quad held", 128'(busReady), 128'd0);
    for (int k = 0; k < 10; k++) begin
      if (memValid && memAddr == QA_C) sawFlush = 1'b1;
      if (rdPass) begin passed = 1'b1; break; end
      @(negedge clk); #1;
    end
    check(passed && sawFlush, "R4", "write-back before read passes",
          128'({passed, sawFlush}), 128'b11);
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic tReadMiss;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = {QA_D, 2'd2};
    #1;
    check(busReady && rdPass && rdQa == QA_D, "R5", "miss passes at once",
          128'({busReady, rdPass, rdQa}), 128'({2'b11, QA_D}));
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic tTimer;
    int at = -1;
    bit early = 1'b0;
    memReady = 1'b1; timeout = 8'd6;
    doWrite(QA_A, 2'd0, 32'h01020304, 4'b1111);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (memValid) begin at = k; break; end
    end
    check(at == 6, "R6", "timer flush cycle", 128'(at), 128'd6);
    @(negedge clk);
    doWrite(QA_A, 2'd1, 32'h11111111, 4'b1111);
    repeat (3) begin @(negedge clk); if (memValid) early = 1'b1; end
    doWrite(QA_A, 2'd2, 32'h22222222, 4'b1111);
    at = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (memValid) begin at = k; break; end
    end
    check(!early && at == 6, "R6", "timer restarted by write", 128'(at), 128'd6);
    @(negedge clk);
  endtask

  task automatic tZero;
    bit any = 1'b0;
    timeout = 8'd0;
    doWrite(QA_A, 2'd3, 32'h0000BEEF, 4'b0011);
    repeat (40) begin @(negedge clk); if (memValid) any = 1'b1; end
    check(!any, "R7", "zero timeout never flushes", 128'(any), 128'd0);
  endtask

  task automatic tDisable;
    memReady = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(memValid && memAddr == QA_A, "R8", "disable flushes merging slot",
          128'(memAddr), 128'(QA_A));
    memReady = 1'b1;
    @(negedge clk);
    doWrite(QA_B, 2'd1, 32'h0000ABCD, 4'b0011);
    @(negedge clk);
    check(memValid && memAddr == QA_B && memByteOff == 16'hFFCF, "R8",
          "disabled write goes straight out", 128'(memByteOff), 128'hFFCF);
    check(memData[47:32] == 16'hABCD, "R9", "byte lanes of single write",
          128'(memData[47:32]), 128'hABCD);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMergeSwap();
    tStall();
    tReadHit();
    tReadMiss();
    tTimer();
    tZero();
    tDisable();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule